// File: doc/BRIEF.md
# Multiplexed converter channel-change sequencer

This block sits between the input multiplexer of a four-input delta-sigma converter and its output register. It samples a 2-bit channel selector on the falling clock edge and passes it through two flip-flops. It compares the settled value with the channel currently being converted. When the two differ, it restarts the conversion, drops any result still in progress and withholds data-ready until the digital filter has settled on the new input.

An abstracted decimation filter supplies a conversion-complete strobe and a 24-bit result word. The block counts strobes after every restart. Only the fifth completed conversion, and every one after it while the channel holds, is written to the output register. Each such write pulls the active-low ready flag low. A read-done strobe from the serial shifter, or a further channel change, releases the flag.

Top module: `adc_mux_sequencer`

## Requirements
- R1: `mux_en` is one-hot and selects the channel being converted: code 0 drives bit 0 (input 1), code 1 bit 1, code 2 bit 2 and code 3 bit 3.
- R2: `chan_sel` is captured on the falling clock edge. A change driven just after rising edge k is acted on at rising edge k+2. Until then `mux_en`, `restart` and `drdy_n` keep their old values.
- R3: At the edge where a change is acted on, the block updates `mux_en`, drives `drdy_n` high and raises `restart` for exactly one cycle. It also clears the settling count, and a strobe arriving in that same cycle is discarded.
- R4: After a reset or a channel change, the first four conversion strobes change neither `result` nor `drdy_n`.
- R5: The fifth strobe after a reset or change loads `conv_data` into `result` and drives `drdy_n` low on the following edge.
- R6: Once settled on an unchanged channel, every strobe loads `result` and drives `drdy_n` low.
- R7: `read_done` drives `drdy_n` high on the next edge. If a result write happens in the same cycle, the write wins and `drdy_n` goes low.
- R8: A synchronous active-high `rst` drives `drdy_n` high, `result` to zero and `restart` low. It clears the settling count and takes the present channel as the reference without signalling a restart.
- R9: `result` holds its value in every cycle without a conversion strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_sel | input | 2 | Requested input channel code |
| conv_done | input | 1 | Filter conversion-complete strobe |
| conv_data | input | 24 | Filter result word |
| read_done | input | 1 | Serial read finished strobe |
| mux_en | output | 4 | One-hot input multiplexer enable |
| restart | output | 1 | One-cycle conversion restart pulse |
| result | output | 24 | Output data register |
| drdy_n | output | 1 | Active-low data-ready flag |

## Verification
A channel change is due two rising edges after it is driven: one falling-edge capture and one second synchroniser stage. The bench checks `mux_en`, `restart` and `drdy_n` at the falling edge after each of those two edges, so both the too-early and the due state are observed. A strobe sampled at a rising edge updates `result` and `drdy_n` by that same edge. A driver task queues the expected word when it issues a strobe that must be written. A monitor compares each observed change of `result` at the next falling edge, which flags both unexpected writes and missing ones.

// File: rtl/adc_mux_sequencer.sv
module adc_mux_sequencer #(
  parameter int DATA_W = 24,
  parameter int SEL_W  = 2,
  parameter int SETTLE = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  chan_sel,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              read_done,
  output logic [(1<<SEL_W)-1:0] mux_en,
  output logic              restart,
  output logic [DATA_W-1:0] result,
  output logic              drdy_n
);
  localparam int NCH   = 1 << SEL_W;
  localparam int CNT_W = $clog2(SETTLE + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SETTLE);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE - 1);

  logic [SEL_W-1:0] sel_fall, sel_sync, sel_ref;
  logic [CNT_W-1:0] cnt_q;
  logic             chg, take, write_res;

  // first stage on the falling edge, second on the rising edge
  always_ff @(negedge clk) sel_fall <= chan_sel;

  always_ff @(posedge clk) begin
    if (rst) sel_sync <= sel_fall;
    else     sel_sync <= sel_fall;
  end

  assign chg       = (sel_sync != sel_ref);
  assign take      = conv_done && !chg;
  assign write_res = take && (cnt_q >= CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_ref <= sel_fall;
      cnt_q   <= '0;
      restart <= 1'b0;
      drdy_n  <= 1'b1;
      result  <= '0;
    end else begin
      restart <= chg;
      if (chg) begin
        sel_ref <= sel_sync;
        cnt_q   <= '0;
        drdy_n  <= 1'b1;
      end else begin
        if (take && cnt_q != CNT_FULL) cnt_q <= cnt_q + 1'b1;
        if (write_res) begin
          result <= conv_data;
          drdy_n <= 1'b0;
        end else if (read_done) begin
          drdy_n <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_dec
    assign mux_en[g] = (sel_ref == SEL_W'(g));
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(mux_en) == 1); // R1
  AST_RESTART_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    restart |-> drdy_n); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_FULL); // R4
  AST_READY_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    $fell(drdy_n) |-> $past(conv_done)); // R5
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (read_done && !conv_done) |=> drdy_n); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !conv_done |=> $stable(result)); // R9
endmodule

// File: tb/test_adc_mux_sequencer.sv
module test_adc_mux_sequencer;
  localparam int PERIOD = 10;

  logic        clk = 0, rst = 1;
  logic [1:0]  chan_sel = 2'd2;
  logic        conv_done = 0, read_done = 0;
  logic [23:0] conv_data = '0;
  logic [3:0]  mux_en;
  logic        restart, drdy_n;
  logic [23:0] result;

  int checks = 0, errors = 0;
  logic [23:0] exp_q[$];
  logic [23:0] last_res;
  bit          mon_on = 0;

  always #(PERIOD/2) clk = ~clk;

  adc_mux_sequencer i_adc_mux_sequencer (
    .clk(clk), .rst(rst), .chan_sel(chan_sel), .conv_done(conv_done),
    .conv_data(conv_data), .read_done(read_done), .mux_en(mux_en),
    .restart(restart), .result(result), .drdy_n(drdy_n));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: every change of result must match the queue head
  always @(negedge clk) if (mon_on && result !== last_res) begin
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL R4: actual %0h expected no update", result);
    end else begin
      logic [23:0] e;
      e = exp_q.pop_front();
      if (result !== e) begin
        errors++;
        $display("FAIL R5: actual %0h expected %0h", result, e);
      end
    end
    last_res = result;
  end

  task automatic strobe(logic [23:0] d, bit expect_wr, bit rd = 0);
    @(posedge clk); #1;
    conv_done = 1; conv_data = d; read_done = rd;
    if (expect_wr) exp_q.push_back(d);
    @(posedge clk); #1;
    conv_done = 0; read_done = 0;
    @(negedge clk);
  endtask

  task automatic pulse_read();
    @(posedge clk); #1 read_done = 1;
    @(posedge clk); #1 read_done = 0;
    @(negedge clk);
  endtask

  task automatic change(logic [1:0] c, logic [3:0] old_en, bit strobe_at_detect);
    @(posedge clk); #1 chan_sel = c;
    @(posedge clk); #1;
    if (strobe_at_detect) begin conv_done = 1; conv_data = 24'hDEAD00; end
    @(negedge clk);
    chk("R2 mux before due", mux_en, old_en);
    chk("R2 no early restart", restart, 0);
    @(posedge clk); #1 conv_done = 0;
    @(negedge clk);
    chk("R1 mux select", mux_en, 4'b0001 << c);
    chk("R3 restart pulse", restart, 1);
    chk("R3 ready released", drdy_n, 1);
    @(negedge clk);
    chk("R3 restart one cycle", restart, 0);
  endtask

  initial begin
    #(PERIOD*2000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk("R8 drdy_n", drdy_n, 1);
    chk("R8 result", result, 0);
    chk("R8 restart", restart, 0);
    chk("R8 mux", mux_en, 4'b0100);
    last_res = result; mon_on = 1;

    for (int i = 0; i < 4; i++) begin
      strobe(24'h100 + i, 0);
      chk("R4 not ready", drdy_n, 1);
    end
    strobe(24'hA5A5A5, 1);
    chk("R5 ready", drdy_n, 0);
    strobe(24'h123456, 1);
    chk("R6 ready", drdy_n, 0);
    pulse_read();
    chk("R7 read release", drdy_n, 1);
    repeat (5) @(negedge clk);
    chk("R9 hold", result, 24'h123456);
    strobe(24'h0F0F0F, 1, 1);
    chk("R7 write wins", drdy_n, 0);

    change(2'd1, 4'b0100, 0);
    for (int i = 0; i < 4; i++) strobe(24'h200 + i, 0);
    chk("R4 after change", drdy_n, 1);
    strobe(24'h654321, 1);
    chk("R5 after change", drdy_n, 0);

    change(2'd3, 4'b0010, 0);
    strobe(24'h300, 0);
    strobe(24'h301, 0);
    change(2'd0, 4'b1000, 1);
    for (int i = 0; i < 4; i++) strobe(24'h400 + i, 0);
    chk("R3 detect strobe discarded", drdy_n, 1);
    strobe(24'hBEEF01, 1);
    chk("R5 input 1 ready", drdy_n, 0);
    pulse_read();
    chk("R7 released", drdy_n, 1);

    repeat (2) @(negedge clk);
    chk("R5 queue drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule